// File: doc/BRIEF.md
# Hot-Plug Slot Controller

This block keeps the slot control and slot status words of a hot-plug capable downstream or root port and decides when the port must signal hot-plug activity to the host. Configuration writes reach it through a simple write port that selects the control or the status word and carries data and byte enables. External inputs report hot-add events, attention button presses and unplug requests. A boot-time population input sets the reset state of the presence and power fields.

Three kinds of event are tracked: attention button pressed, presence detect changed and command completed. An interrupt-pending level is derived from the status bits, their matching enables and the master hot-plug interrupt enable. The block notifies only when that level changes. The notification is a message request carrying a 5-bit vector when MSI-X or MSI is enabled, and otherwise a level on the legacy INTx output. A control write that turns power off together with the power indicator removes the adapter and pulses a removal strobe. Requests that arrive while the electromechanical interlock is engaged are refused with a busy pulse.

Top module: `hp_slot_ctrl`

## Requirements
- R1: During reset the control word becomes: attention indicator bits 7:6 = 11 (off), all event enables (bits 0, 3, 4) and the interrupt enable (bit 5) cleared. With a power controller, bit 10 is power-off = NOT boot_present and the power indicator bits 9:8 = 01 (on) when boot_present is 1, or 11 (off) when it is 0. Indicator encoding is 01 on, 10 blink, 11 off.
- R2: During reset the status word becomes zero except presence-detect state (bit 6), which takes boot_present.
- R3: The pending level is enable bit 5 AND any of (status AND control AND 0x0019). With msix_en and msi_en both low, a change of that level drives intx to the new level.
- R4: A notification becomes a one-cycle msg_req carrying vec_in when msix_en is set (msg_msix=1) or else when msi_en is set (msg_msix=0). In those modes intx is not changed.
- R5: A status write clears only the event bits 0 (attention), 3 (presence changed) and 4 (command completed) that are written with 1. Presence state (bit 6) and interlock state (bit 7) are unaffected. The pending level is re-evaluated and no message is sent. With no message mode enabled and the level false, intx drops.
- R6: Raising an event when any of its status bits is already set sets the bits but gives no notification.
- R7: Every control write raises the command-completed event (status bit 4) after its other effects.
- R8: A control write with bit 11 set, and byte 1 enabled, toggles interlock status bit 7. Control bit 11 always reads 0.
- R9: When presence state is 1 and a control write sets bit 10 with bits 9:8 = 11, remove_stb pulses for one cycle, presence state clears and presence-changed (bit 3) sets. Otherwise no removal happens.
- R10: hot_add sets presence state and raises presence-changed plus attention. attn_push, and unplug_req when not refused, raise attention.
- R11: While interlock status is 1, hot_add and unplug_req pulse busy and leave the status word unchanged.
- R12: Byte enables gate each byte of a control write. Unwritable control bits hold their value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_sel_sts | input | 1 | 1 selects the status word, 0 the control word |
| cfg_wdata | input | 16 | Write data |
| cfg_be | input | 2 | Byte enables |
| boot_present | input | 1 | Adapter populated at power-up, used during reset |
| hot_add | input | 1 | Hot-add event pulse |
| attn_push | input | 1 | Attention button press pulse |
| unplug_req | input | 1 | Unplug request pulse |
| msix_en | input | 1 | MSI-X enabled |
| msi_en | input | 1 | MSI enabled |
| vec_in | input | 5 | Message vector for hot-plug notifications |
| rd_ctl | output | 16 | Current control word |
| rd_sts | output | 16 | Current status word |
| intx | output | 1 | Legacy interrupt level |
| msg_req | output | 1 | One-cycle message request |
| msg_msix | output | 1 | Message type of msg_req: 1 MSI-X, 0 MSI |
| msg_vec | output | 5 | Vector of the current message |
| remove_stb | output | 1 | Adapter removal strobe |
| busy | output | 1 | Request refused because the interlock is engaged |

## Verification
The assertions assume that the event inputs are single-cycle pulses and that the message-mode flags change only between transactions. They also assume that only one configuration write is in flight per cycle, so a same-cycle hot-add never competes with a status write for the presence bit. The directed stimulus drives every input on the falling clock edge and applies one transaction per cycle. It restarts each scenario from a fresh reset, so every check starts from a known control and status word.

// File: rtl/hp_slot_pkg.sv
// Shared field positions, indicator codes and event-stage helpers for the
// hot-plug slot controller. Assumes a 16-bit control and status word.
package hp_slot_pkg;
    localparam int CW = 16;

    // control word fields
    localparam int CTL_ABP_EN   = 0;
    localparam int CTL_PDC_EN   = 3;
    localparam int CTL_CC_EN    = 4;
    localparam int CTL_HPIE     = 5;
    localparam int CTL_ATTN_LO  = 6;
    localparam int CTL_PWRI_LO  = 8;
    localparam int CTL_PWR_OFF  = 10;
    localparam int CTL_LOCK_TGL = 11;

    // status word fields
    localparam int STS_ABP  = 0;
    localparam int STS_PDC  = 3;
    localparam int STS_CC   = 4;
    localparam int STS_PDS  = 6;
    localparam int STS_LOCK = 7;

    localparam logic [CW-1:0] EVT_MASK =
        CW'((1 << STS_ABP) | (1 << STS_PDC) | (1 << STS_CC));

    typedef enum logic [1:0] {
        IND_RSVD  = 2'b00,
        IND_ON    = 2'b01,
        IND_BLINK = 2'b10,
        IND_OFF   = 2'b11
    } ind_e;

    typedef struct packed {
        logic [CW-1:0] sts;
        logic          pend;
        logic          fire;
    } stage_t;

    // Derived interrupt-pending level.
    function automatic logic pend_eval(input logic [CW-1:0] ctl,
                                       input logic [CW-1:0] sts);
        return ctl[CTL_HPIE] && (|(sts & ctl & EVT_MASK));
    endfunction

    // Re-evaluate the level and note whether it changed.
    function automatic stage_t reeval(input stage_t in, input logic [CW-1:0] ctl);
        stage_t o;
        o      = in;
        o.pend = pend_eval(ctl, in.sts);
        o.fire = in.fire | (o.pend != in.pend);
        return o;
    endfunction

    // Raise event bits; an already-set bit suppresses evaluation.
    function automatic stage_t raise_evt(input stage_t in, input logic [CW-1:0] ctl,
                                         input logic [CW-1:0] ev);
        stage_t o;
        o     = in;
        o.sts = in.sts | ev;
        if (!(|(in.sts & ev))) begin
            o = reeval(o, ctl);
        end
        return o;
    endfunction
endpackage

// File: rtl/hp_ctl_reg.sv
// Slot control register. Merges byte-enabled writes into the writable bits,
// decodes the interlock toggle and the power-off-with-indicator-off request.
// Assumes at most one write per cycle; boot_present is stable during reset.
module hp_ctl_reg
    import hp_slot_pkg::*;
#(
    parameter bit HAS_PWR_CTL = 1'b1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          boot_present,
    input  logic          wr_en,
    input  logic [CW-1:0] wdata,
    input  logic [CW-1:0] bmask,
    output logic [CW-1:0] ctl_q,
    output logic [CW-1:0] ctl_nx,
    output logic          lock_tgl,
    output logic          off_req
);
    localparam logic [CW-1:0] WMASK_BASE = CW'((1 << CTL_ABP_EN) | (1 << CTL_PDC_EN) |
        (1 << CTL_CC_EN) | (1 << CTL_HPIE) | (3 << CTL_ATTN_LO) | (3 << CTL_PWRI_LO));
    localparam logic [CW-1:0] WMASK = HAS_PWR_CTL ?
        (WMASK_BASE | CW'(1 << CTL_PWR_OFF)) : WMASK_BASE;

    logic [CW-1:0] rst_val;

    // Reset value: attention off, power fields from boot population.
    always_comb begin
        rst_val = '0;
        rst_val[CTL_ATTN_LO +: 2] = IND_OFF;
        if (HAS_PWR_CTL) begin
            rst_val[CTL_PWRI_LO +: 2] = boot_present ? IND_ON : IND_OFF;
            rst_val[CTL_PWR_OFF]      = ~boot_present;
        end
    end

    // Next value after a byte-enabled write.
    always_comb begin
        ctl_nx = ctl_q;
        if (wr_en) begin
            ctl_nx = (ctl_q & ~(WMASK & bmask)) | (wdata & WMASK & bmask);
        end
    end

    // Side effects decoded from the written data.
    always_comb begin
        lock_tgl = wr_en && bmask[CTL_LOCK_TGL] && wdata[CTL_LOCK_TGL];
        off_req  = wr_en && bmask[CTL_PWR_OFF] && bmask[CTL_PWRI_LO] &&
                   wdata[CTL_PWR_OFF] && (wdata[CTL_PWRI_LO +: 2] == IND_OFF);
    end

    // Control register state.
    always_ff @(posedge clk) begin
        if (!rst_n) ctl_q <= rst_val;
        else        ctl_q <= ctl_nx;
    end
endmodule

// File: rtl/hp_evt_engine.sv
// Combinational event chain: status clear, control write effects, command
// completed, then external events, each stage updating the pending level.
// Assumes event inputs are single-cycle pulses.
module hp_evt_engine
    import hp_slot_pkg::*;
(
    input  logic [CW-1:0] sts_q,
    input  logic          pend_q,
    input  logic [CW-1:0] ctl_q,
    input  logic [CW-1:0] ctl_nx,
    input  logic          ctl_wr,
    input  logic          sts_wr,
    input  logic [CW-1:0] sts_clr,
    input  logic          lock_tgl,
    input  logic          off_req,
    input  logic          hot_add,
    input  logic          attn_push,
    input  logic          unplug_req,
    input  logic          msix_en,
    input  logic          msi_en,
    output logic [CW-1:0] sts_nx,
    output logic          pend_nx,
    output logic          fire,
    output logic          clr_intx,
    output logic          busy_nx,
    output logic          remove_nx
);
    localparam logic [CW-1:0] EV_ABP = CW'(1 << STS_ABP);
    localparam logic [CW-1:0] EV_PDC = CW'(1 << STS_PDC);
    localparam logic [CW-1:0] EV_CC  = CW'(1 << STS_CC);

    logic   locked;
    stage_t st;

    // Interlock state at the start of the cycle gates requests.
    always_comb begin
        locked  = sts_q[STS_LOCK];
        busy_nx = (hot_add || unplug_req) && locked;
    end

    // Ordered event stages.
    always_comb begin
        st.sts    = sts_q;
        st.pend   = pend_q;
        st.fire   = 1'b0;
        clr_intx  = 1'b0;
        remove_nx = 1'b0;
        if (sts_wr) begin
            st.sts   = st.sts & ~sts_clr;
            st.pend  = pend_eval(ctl_q, st.sts);
            clr_intx = !msix_en && !msi_en && !st.pend;
        end
        if (ctl_wr) begin
            if (lock_tgl) st.sts[STS_LOCK] = ~st.sts[STS_LOCK];
            if (off_req && st.sts[STS_PDS]) begin
                remove_nx          = 1'b1;
                st.sts[STS_PDS]    = 1'b0;
                st.sts[STS_PDC]    = 1'b1;
            end
            st = reeval(st, ctl_nx);
            st = raise_evt(st, ctl_nx, EV_CC);
        end
        if (hot_add && !locked) begin
            st.sts[STS_PDS] = 1'b1;
            st = raise_evt(st, ctl_nx, EV_PDC | EV_ABP);
        end
        if (attn_push) begin
            st = raise_evt(st, ctl_nx, EV_ABP);
        end
        if (unplug_req && !locked) begin
            st = raise_evt(st, ctl_nx, EV_ABP);
        end
        sts_nx  = st.sts;
        pend_nx = st.pend;
        fire    = st.fire;
    end
endmodule

// File: rtl/hp_notify.sv
// Notification router: MSI-X first, then MSI, else INTx level. Also registers
// the removal and busy pulses. Assumes the mode flags are quasi-static.
module hp_notify #(
    parameter int VEC_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             fire,
    input  logic             pend,
    input  logic             clr_intx,
    input  logic             msix_en,
    input  logic             msi_en,
    input  logic [VEC_W-1:0] vec_in,
    input  logic             remove_in,
    input  logic             busy_in,
    output logic             intx,
    output logic             msg_req,
    output logic             msg_msix,
    output logic [VEC_W-1:0] msg_vec,
    output logic             remove_stb,
    output logic             busy
);
    // Route a level change to a message or to the INTx level.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            intx     <= 1'b0;
            msg_req  <= 1'b0;
            msg_msix <= 1'b0;
            msg_vec  <= '0;
        end else begin
            msg_req <= 1'b0;
            if (fire && (msix_en || msi_en)) begin
                msg_req  <= 1'b1;
                msg_msix <= msix_en;
                msg_vec  <= vec_in;
            end else if (fire) begin
                intx <= pend;
            end else if (clr_intx) begin
                intx <= 1'b0;
            end
        end
    end

    // One-cycle strobes for removal and refused requests.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            remove_stb <= 1'b0;
            busy       <= 1'b0;
        end else begin
            remove_stb <= remove_in;
            busy       <= busy_in;
        end
    end
endmodule

// File: rtl/hp_slot_ctrl.sv
// Top of the hot-plug slot controller: holds the status word and pending
// level, and wires control register, event chain and notifier together.
// Assumes one configuration write per cycle and pulsed event inputs.
module hp_slot_ctrl
    import hp_slot_pkg::*;
#(
    parameter int VEC_W       = 5,
    parameter bit HAS_PWR_CTL = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_wr,
    input  logic             cfg_sel_sts,
    input  logic [15:0]      cfg_wdata,
    input  logic [1:0]       cfg_be,
    input  logic             boot_present,
    input  logic             hot_add,
    input  logic             attn_push,
    input  logic             unplug_req,
    input  logic             msix_en,
    input  logic             msi_en,
    input  logic [VEC_W-1:0] vec_in,
    output logic [15:0]      rd_ctl,
    output logic [15:0]      rd_sts,
    output logic             intx,
    output logic             msg_req,
    output logic             msg_msix,
    output logic [VEC_W-1:0] msg_vec,
    output logic             remove_stb,
    output logic             busy
);
    localparam int NBYTE = CW / 8;

    logic [CW-1:0] bmask;
    logic [CW-1:0] ctl_q, ctl_nx, sts_q, sts_nx, sts_clr;
    logic          pend_q, pend_nx, fire, clr_intx, busy_nx, remove_nx;
    logic          lock_tgl, off_req, ctl_wr, sts_wr;

    for (genvar b = 0; b < NBYTE; b++) begin : g_bmask
        assign bmask[b*8 +: 8] = {8{cfg_be[b]}};
    end

    // Decode the write target and the write-one-to-clear set.
    always_comb begin
        ctl_wr  = cfg_wr && !cfg_sel_sts;
        sts_wr  = cfg_wr && cfg_sel_sts;
        sts_clr = cfg_wdata & bmask & EVT_MASK;
    end

    hp_ctl_reg #(.HAS_PWR_CTL(HAS_PWR_CTL)) u_ctl (
        .clk, .rst_n, .boot_present,
        .wr_en(ctl_wr), .wdata(cfg_wdata), .bmask,
        .ctl_q, .ctl_nx, .lock_tgl, .off_req
    );

    hp_evt_engine u_evt (
        .sts_q, .pend_q, .ctl_q, .ctl_nx, .ctl_wr, .sts_wr, .sts_clr,
        .lock_tgl, .off_req, .hot_add, .attn_push, .unplug_req,
        .msix_en, .msi_en, .sts_nx, .pend_nx, .fire, .clr_intx,
        .busy_nx, .remove_nx
    );

    // Status word and pending level state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sts_q          <= '0;
            sts_q[STS_PDS] <= boot_present;
            pend_q         <= 1'b0;
        end else begin
            sts_q  <= sts_nx;
            pend_q <= pend_nx;
        end
    end

    hp_notify #(.VEC_W(VEC_W)) u_ntf (
        .clk, .rst_n, .fire, .pend(pend_nx), .clr_intx, .msix_en, .msi_en,
        .vec_in, .remove_in(remove_nx), .busy_in(busy_nx),
        .intx, .msg_req, .msg_msix, .msg_vec, .remove_stb, .busy
    );

    assign rd_ctl = ctl_q;
    assign rd_sts = sts_q;
endmodule

// File: rtl/hp_slot_chk.sv
// Port-level properties of the hot-plug slot controller, bound to the top.
module hp_slot_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        cfg_wr,
    input logic        cfg_sel_sts,
    input logic [15:0] cfg_wdata,
    input logic [1:0]  cfg_be,
    input logic        hot_add,
    input logic        msix_en,
    input logic        msi_en,
    input logic [15:0] rd_sts,
    input logic        intx,
    input logic        msg_req,
    input logic        msg_msix,
    input logic        remove_stb,
    input logic        busy
);
    AST_CC_AFTER_CTL_WR: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_wr && !cfg_sel_sts) |=> rd_sts[4]); // R7
    AST_LOCK_TOGGLES: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_wr && !cfg_sel_sts && cfg_be[1] && cfg_wdata[11])
        |=> (rd_sts[7] != $past(rd_sts[7]))); // R8
    AST_LOCK_REFUSES_ADD: assert property (@(posedge clk) disable iff (!rst_n)
        (hot_add && rd_sts[7] && !cfg_wr) |=> (busy && (rd_sts[6] == $past(rd_sts[6])))); // R11
    AST_REMOVE_STATE: assert property (@(posedge clk) disable iff (!rst_n)
        remove_stb |-> (!rd_sts[6] && rd_sts[3])); // R9
    AST_MSG_NEEDS_MODE: assert property (@(posedge clk) disable iff (!rst_n)
        msg_req |-> $past(msix_en || msi_en)); // R4
    AST_MSIX_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        (msg_req && msg_msix) |-> $past(msix_en)); // R4
    AST_INTX_LEGACY_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(intx) |-> $past(!msix_en && !msi_en)); // R3
    AST_STS_WR_KEEPS_PDS: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_wr && cfg_sel_sts && !hot_add) |=> (rd_sts[6] == $past(rd_sts[6]))); // R5
endmodule

bind hp_slot_ctrl hp_slot_chk u_hp_slot_chk (.*);

// File: tb/test_hp_slot_ctrl.sv
`timescale 1ns/1ps
module test_hp_slot_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_wr = 1'b0;
    logic        cfg_sel_sts = 1'b0;
    logic [15:0] cfg_wdata = '0;
    logic [1:0]  cfg_be = '0;
    logic        boot_present = 1'b0;
    logic        hot_add = 1'b0;
    logic        attn_push = 1'b0;
    logic        unplug_req = 1'b0;
    logic        msix_en = 1'b0;
    logic        msi_en = 1'b0;
    logic [4:0]  vec_in = 5'd19;
    logic [15:0] rd_ctl, rd_sts;
    logic        intx, msg_req, msg_msix, remove_stb, busy;
    logic [4:0]  msg_vec;

    int n_run = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    hp_slot_ctrl i_hp_slot_ctrl (
        .clk, .rst_n, .cfg_wr, .cfg_sel_sts, .cfg_wdata, .cfg_be, .boot_present,
        .hot_add, .attn_push, .unplug_req, .msix_en, .msi_en, .vec_in,
        .rd_ctl, .rd_sts, .intx, .msg_req, .msg_msix, .msg_vec, .remove_stb, .busy
    );

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic do_reset(input logic pres);
        @(negedge clk);
        boot_present = pres;
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic wr(input logic sel, input logic [15:0] d, input logic [1:0] be);
        cfg_wr = 1'b1; cfg_sel_sts = sel; cfg_wdata = d; cfg_be = be;
        @(negedge clk);
        cfg_wr = 1'b0; cfg_be = '0;
    endtask

    task automatic pulse(input int which);
        if (which == 0) hot_add = 1'b1;
        if (which == 1) attn_push = 1'b1;
        if (which == 2) unplug_req = 1'b1;
        @(negedge clk);
        hot_add = 1'b0; attn_push = 1'b0; unplug_req = 1'b0;
    endtask

    task automatic t_reset;
        do_reset(1'b0);
        chk("R1 ctl reset empty slot", rd_ctl, 16'h07C0);
        chk("R2 sts reset empty slot", rd_sts, 16'h0000);
        chk("R3 intx reset", {15'd0, intx}, 16'd0);
        do_reset(1'b1);
        chk("R1 ctl reset populated", rd_ctl, 16'h01C0);
        chk("R2 sts reset populated", rd_sts, 16'h0040);
    endtask

    task automatic t_intx;
        msix_en = 1'b0; msi_en = 1'b0;
        do_reset(1'b0);
        wr(1'b0, 16'h07F0, 2'b11);
        chk("R7 cc set", rd_sts, 16'h0010);
        chk("R3 intx follows level", {15'd0, intx}, 16'd1);
        chk("R3 no message", {15'd0, msg_req}, 16'd0);
        wr(1'b1, 16'h0010, 2'b11);
        chk("R5 w1c cc", rd_sts, 16'h0000);
        chk("R5 intx drops", {15'd0, intx}, 16'd0);
    endtask

    task automatic t_msg;
        msix_en = 1'b0; msi_en = 1'b1;
        do_reset(1'b0);
        wr(1'b0, 16'h07E1, 2'b11);
        chk("R7 cc disabled no msg", {15'd0, msg_req}, 16'd0);
        pulse(1);
        chk("R10 attn sets abp", rd_sts, 16'h0011);
        chk("R4 msi msg", {msg_req, msg_msix, 9'd0, msg_vec}, {2'b10, 9'd0, 5'd19});
        @(negedge clk);
        chk("R4 msg one cycle", {15'd0, msg_req}, 16'd0);
        pulse(1);
        chk("R6 no renotify", {15'd0, msg_req}, 16'd0);
        chk("R4 intx untouched", {15'd0, intx}, 16'd0);
        wr(1'b1, 16'h0001, 2'b01);
        chk("R5 w1c no msg", {msg_req, rd_sts[14:0]}, 16'h0010);
        msix_en = 1'b1;
        pulse(1);
        chk("R4 msix first", {14'd0, msg_req, msg_msix}, 16'd3);
        msix_en = 1'b0; msi_en = 1'b0;
    endtask

    task automatic t_lock;
        do_reset(1'b0);
        wr(1'b0, 16'h0FC0, 2'b11);
        chk("R8 lock toggles on", rd_sts, 16'h0090);
        chk("R8 ctl bit11 reads 0", rd_ctl, 16'h07C0);
        pulse(0);
        chk("R11 add refused busy", {15'd0, busy}, 16'd1);
        chk("R11 add no change", rd_sts, 16'h0090);
        pulse(2);
        chk("R11 unplug refused", {busy, rd_sts[14:0]}, 16'h8090);
        wr(1'b0, 16'h0FC0, 2'b11);
        chk("R8 lock toggles off", rd_sts, 16'h0010);
        pulse(2);
        chk("R10 unplug raises abp", {busy, rd_sts[14:0]}, 16'h0011);
    endtask

    task automatic t_hotplug;
        msix_en = 1'b0; msi_en = 1'b0;
        do_reset(1'b0);
        wr(1'b0, 16'h07E9, 2'b11);
        chk("R3 cc not enabled", {15'd0, intx}, 16'd0);
        pulse(0);
        chk("R10 hot add", rd_sts, 16'h0059);
        chk("R3 intx on add", {15'd0, intx}, 16'd1);
        wr(1'b1, 16'h0049, 2'b11);
        chk("R5 pds not cleared", rd_sts, 16'h0050);
        chk("R5 intx dropped", {15'd0, intx}, 16'd0);
        wr(1'b0, 16'h07E9, 2'b11);
        chk("R9 removal strobe", {15'd0, remove_stb}, 16'd1);
        chk("R9 removal status", rd_sts, 16'h0018);
        chk("R3 intx on removal", {15'd0, intx}, 16'd1);
        @(negedge clk);
        chk("R9 strobe one cycle", {15'd0, remove_stb}, 16'd0);
        do_reset(1'b1);
        wr(1'b0, 16'h0540, 2'b11);
        chk("R9 no removal indicator on", {remove_stb, rd_sts[14:0]}, 16'h0050);
        chk("R12 full write", rd_ctl, 16'h0540);
    endtask

    task automatic t_bytes;
        msix_en = 1'b0; msi_en = 1'b0;
        do_reset(1'b0);
        wr(1'b0, 16'h0030, 2'b01);
        chk("R12 low byte only", rd_ctl, 16'h0730);
        chk("R12 no removal high byte off", {15'd0, remove_stb}, 16'd0);
        chk("R7 cc with low byte write", {intx, rd_sts[14:0]}, 16'h8010);
    endtask

    initial begin
        t_reset();
        t_intx();
        t_msg();
        t_lock();
        t_hotplug();
        t_bytes();
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        #(20000 * 5);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule